// File: doc/BRIEF.md
# Posted-Write Burst SRAM with Read Forwarding

This block is a synthesizable behavioural model of a synchronous SRAM core. Every access moves a fixed burst of four words. A write burst is not stored in the array while it arrives. It is parked in a single posted-write register, together with the active-low byte enables of each word. The parked burst is written into the array only when the next write command is accepted, and that new burst then takes its place in the register. Until then, any read of the parked burst address is served from the register. Bytes that were enabled come from the register and all other bytes come from the array. The user therefore always reads the most recent data, even right after the write.

Commands use a valid strobe, a write/read select and a word address. The two low address bits are ignored and the burst runs through words 0 to 3 in linear order. A central controller has three states:

- IDLE accepts a command.
- READ runs a read burst.
- WRITE runs a write burst.

The named transitions are:

- IDLE→READ: read accept.
- IDLE→WRITE: write accept.
- READ→READ and WRITE→WRITE: beat advance.
- READ→IDLE and WRITE→IDLE: burst end, after beat 3.

The controller also counts idle cycles after a read burst. It pulses `turn_err` when a write arrives with fewer idle cycles than the `TURN_NOPS` parameter. That write is still carried out.

Top module: `posted_write_sram`

## Requirements
- R1: After reset, `rd_valid` and `turn_err` are 0 and no posted write is pending. A burst that was still held in the register when reset arrived is discarded, so a later read of its address returns the older array contents. Reset also clears the turnaround history.
- R2: A write command is accepted in an idle cycle. Word 0 and its enables are taken in the command cycle, and words 1, 2 and 3 in the three following cycles. The word at index k belongs to position k of the burst.
- R3: The held burst is committed to the array when the next write command is accepted. After that, reads of its address return its data from the array.
- R4: A read of the pending burst address returns the held data. This holds even when the read command comes in the cycle right after the last write beat.
- R5: In `wr_be_n`, bit j low enables byte j (bits 8j+7..8j) of the word sampled in the same cycle. A disabled byte keeps the value it had before, both while the burst is pending and after it is committed.
- R6: After an accepted read command, `rd_valid` is high for exactly the four following cycles, with `rd_data` carrying words 0, 1, 2 and 3 in that order. At all other times `rd_valid` is low.
- R7: `cmd_valid` in the three cycles that follow an accepted command is ignored. It does not change the stored data and starts no read.
- R8: `turn_err` is high for one cycle, the cycle after a write command is accepted, when the previous command was a read and fewer than `TURN_NOPS` idle cycles without `cmd_valid` passed after that read burst ended. That write is still performed. A read that follows a write, or a write that follows a write, never raises `turn_err`.
- R9: Bits 1..0 of `cmd_addr` do not affect which burst is accessed or the word order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken only in an idle cycle |
| cmd_write | input | 1 | 1 = write burst, 0 = read burst |
| cmd_addr | input | ADDR_W | Word address; the upper bits select the burst |
| wr_data | input | DATA_W | Write word for the current beat |
| wr_be_n | input | DATA_W/8 | Active-low byte enables for `wr_data` |
| rd_valid | output | 1 | Read word strobe |
| rd_data | output | DATA_W | Read word, burst order 0..3 |
| turn_err | output | 1 | One-cycle pulse: write came too soon after a read |

## Verification
Faults in the posted-write register appear as wrong bytes on `rd_data`. A wrong enable bit or a wrong match on the parked address shows up in the very next read of that burst. A commit that is lost or too early only shows up on the first read after the following write, or after a reset. If the beat counter or the state drifts, `rd_valid` gets the wrong length, or words appear in the wrong order, within four cycles of a command. A fault in the idle counter flips `turn_err` one cycle after the write it concerns.

// File: rtl/pws_pkg.sv
package pws_pkg;

    localparam int BURST_LEN = 4;
    localparam int BEAT_W    = 2;
    localparam logic [BEAT_W-1:0] LAST_BEAT = '1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE
    } pws_state_e;

endpackage

// File: rtl/pws_ctrl.sv
module pws_ctrl
    import pws_pkg::*;
#(
    parameter int TURN_NOPS = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    output pws_state_e        state,
    output logic [BEAT_W-1:0] beat,
    output logic              rd_accept,
    output logic              wr_accept,
    output logic              turn_err
);

    localparam int CNT_W = $clog2(TURN_NOPS + 1) + 1;
    localparam logic [CNT_W-1:0] NOP_LIMIT = CNT_W'(TURN_NOPS);

    pws_state_e        state_nx;
    logic [BEAT_W-1:0] beat_nx;
    logic              last_rd;
    logic [CNT_W-1:0]  nop_cnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            beat  <= '0;
        end else begin
            state <= state_nx;
            beat  <= beat_nx;
        end
    end

    // next state and accept strobes
    always_comb begin
        rd_accept = 1'b0;
        wr_accept = 1'b0;
        state_nx  = state;
        beat_nx   = beat;
        unique case (state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    if (cmd_write) begin
                        wr_accept = 1'b1;
                        state_nx  = ST_WRITE;
                    end else begin
                        rd_accept = 1'b1;
                        state_nx  = ST_READ;
                    end
                    beat_nx = BEAT_W'(1);
                end
            end
            ST_READ, ST_WRITE: begin
                if (beat == LAST_BEAT) begin
                    state_nx = ST_IDLE;
                    beat_nx  = '0;
                end else begin
                    beat_nx = beat + BEAT_W'(1);
                end
            end
            default: begin
                state_nx = ST_IDLE;
                beat_nx  = '0;
            end
        endcase
    end

    // turnaround tracking: idle cycles counted since the last read burst
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_rd  <= 1'b0;
            nop_cnt  <= '0;
            turn_err <= 1'b0;
        end else begin
            turn_err <= 1'b0;
            if (rd_accept) begin
                last_rd <= 1'b1;
                nop_cnt <= '0;
            end else if (wr_accept) begin
                last_rd  <= 1'b0;
                turn_err <= last_rd && (nop_cnt < NOP_LIMIT);
            end else if (state == ST_IDLE && nop_cnt < NOP_LIMIT) begin
                nop_cnt <= nop_cnt + CNT_W'(1);
            end
        end
    end

    // R7: a burst always closes after its last beat
    p_burst_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && beat == LAST_BEAT) |=> (state == ST_IDLE));

    // R8: the error is a single-cycle pulse
    p_err_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        turn_err |=> !turn_err);

    // R8: the error only follows an accepted write
    p_err_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        turn_err |-> $past(wr_accept));

endmodule

// File: rtl/pws_posted.sv
module pws_posted
    import pws_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int BADDR_W = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_accept,
    input  logic                                wr_beat_en,
    input  logic [BEAT_W-1:0]                   beat,
    input  logic [BADDR_W-1:0]                  cmd_burst,
    input  logic [DATA_W-1:0]                   wr_data,
    input  logic [DATA_W/8-1:0]                 wr_be_n,
    input  logic [BURST_LEN-1:0][DATA_W-1:0]    raw_words,
    output logic                                pw_valid,
    output logic [BADDR_W-1:0]                  pw_burst,
    output logic [BURST_LEN-1:0][DATA_W-1:0]    pw_data,
    output logic [BURST_LEN-1:0][DATA_W/8-1:0]  pw_be_n,
    output logic [BURST_LEN-1:0][DATA_W-1:0]    fwd_words
);

    localparam int NBYTES = DATA_W / 8;

    logic hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pw_valid <= 1'b0;
            pw_burst <= '0;
            pw_data  <= '0;
            pw_be_n  <= '1;
        end else if (wr_accept) begin
            pw_valid   <= 1'b1;
            pw_burst   <= cmd_burst;
            pw_data[0] <= wr_data;
            pw_be_n    <= {{(BURST_LEN-1)*NBYTES{1'b1}}, wr_be_n};
        end else if (wr_beat_en) begin
            pw_data[beat] <= wr_data;
            pw_be_n[beat] <= wr_be_n;
        end
    end

    assign hit = pw_valid && (pw_burst == cmd_burst);

    for (genvar k = 0; k < BURST_LEN; k++) begin : g_word
        for (genvar j = 0; j < NBYTES; j++) begin : g_byte
            assign fwd_words[k][j*8 +: 8] = (hit && !pw_be_n[k][j])
                                          ? pw_data[k][j*8 +: 8]
                                          : raw_words[k][j*8 +: 8];
        end
    end

    // R3: an accepted write always leaves a burst pending
    p_pending_after_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_accept |=> (pw_valid && pw_burst == $past(cmd_burst)));

endmodule

// File: rtl/pws_array.sv
module pws_array
    import pws_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int BADDR_W = 8
) (
    input  logic                                clk,
    input  logic                                commit_en,
    input  logic [BADDR_W-1:0]                  commit_burst,
    input  logic [BURST_LEN-1:0][DATA_W-1:0]    commit_data,
    input  logic [BURST_LEN-1:0][DATA_W/8-1:0]  commit_be_n,
    input  logic [BADDR_W-1:0]                  rd_burst,
    output logic [BURST_LEN-1:0][DATA_W-1:0]    raw_words
);

    localparam int NBURST = 1 << BADDR_W;
    localparam int NBYTES = DATA_W / 8;

    logic [BURST_LEN-1:0][DATA_W-1:0] mem [NBURST];

    always_ff @(posedge clk) begin
        if (commit_en) begin
            for (int k = 0; k < BURST_LEN; k++) begin
                for (int j = 0; j < NBYTES; j++) begin
                    if (!commit_be_n[k][j]) begin
                        mem[commit_burst][k][j*8 +: 8] <= commit_data[k][j*8 +: 8];
                    end
                end
            end
        end
    end

    assign raw_words = mem[rd_burst];

endmodule

// File: rtl/posted_write_sram.sv
module posted_write_sram
    import pws_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 32,
    parameter int TURN_NOPS = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic                cmd_write,
    input  logic [ADDR_W-1:0]   cmd_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [DATA_W/8-1:0] wr_be_n,
    output logic                rd_valid,
    output logic [DATA_W-1:0]   rd_data,
    output logic                turn_err
);

    localparam int BADDR_W = ADDR_W - BEAT_W;
    localparam int NBYTES  = DATA_W / 8;

    pws_state_e                       state;
    logic [BEAT_W-1:0]                beat;
    logic                             rd_accept;
    logic                             wr_accept;
    logic [BADDR_W-1:0]               cmd_burst;
    logic                             pw_valid;
    logic [BADDR_W-1:0]               pw_burst;
    logic [BURST_LEN-1:0][DATA_W-1:0] pw_data;
    logic [BURST_LEN-1:0][NBYTES-1:0] pw_be_n;
    logic [BURST_LEN-1:0][DATA_W-1:0] raw_words;
    logic [BURST_LEN-1:0][DATA_W-1:0] fwd_words;
    logic [BURST_LEN-1:0][DATA_W-1:0] rd_buf;
    logic                             unused_low_bits;

    assign cmd_burst       = cmd_addr[ADDR_W-1:BEAT_W];
    assign unused_low_bits = ^cmd_addr[BEAT_W-1:0];

    pws_ctrl #(.TURN_NOPS(TURN_NOPS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_write (cmd_write),
        .state     (state),
        .beat      (beat),
        .rd_accept (rd_accept),
        .wr_accept (wr_accept),
        .turn_err  (turn_err)
    );

    pws_posted #(.DATA_W(DATA_W), .BADDR_W(BADDR_W)) u_posted (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_accept  (wr_accept),
        .wr_beat_en (state == ST_WRITE),
        .beat       (beat),
        .cmd_burst  (cmd_burst),
        .wr_data    (wr_data),
        .wr_be_n    (wr_be_n),
        .raw_words  (raw_words),
        .pw_valid   (pw_valid),
        .pw_burst   (pw_burst),
        .pw_data    (pw_data),
        .pw_be_n    (pw_be_n),
        .fwd_words  (fwd_words)
    );

    pws_array #(.DATA_W(DATA_W), .BADDR_W(BADDR_W)) u_array (
        .clk          (clk),
        .commit_en    (wr_accept && pw_valid),
        .commit_burst (pw_burst),
        .commit_data  (pw_data),
        .commit_be_n  (pw_be_n),
        .rd_burst     (cmd_burst),
        .raw_words    (raw_words)
    );

    // read output: word 0 leaves with the accept, the rest from the buffer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            rd_buf   <= '0;
        end else if (rd_accept) begin
            rd_valid <= 1'b1;
            rd_data  <= fwd_words[0];
            rd_buf   <= fwd_words;
        end else if (state == ST_READ) begin
            rd_valid <= 1'b1;
            rd_data  <= rd_buf[beat];
        end else begin
            rd_valid <= 1'b0;
        end
    end

    // R6: read strobe starts right after the accept
    p_rd_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_accept |=> rd_valid);

    // R6: read strobe only inside a read window
    p_rd_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(rd_accept) || $past(state) == ST_READ));

endmodule

// File: tb/tb_posted_write_sram.sv
module tb_posted_write_sram;

    localparam int AW = 5;
    localparam int DW = 16;
    localparam int TN = 2;
    localparam int NB = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_write = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [1:0]    wr_be_n = '1;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic          turn_err;

    posted_write_sram #(.ADDR_W(AW), .DATA_W(DW), .TURN_NOPS(TN)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .wr_data(wr_data), .wr_be_n(wr_be_n),
        .rd_valid(rd_valid), .rd_data(rd_data), .turn_err(turn_err)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // reference model
    logic [DW-1:0] mem_m [NB][4];
    bit            p_v = 0;
    int            p_b = 0;
    logic [DW-1:0] p_d [4];
    logic [1:0]    p_be [4];
    bit            last_rd = 0;
    int            rd_end = 0;

    // expectation rings indexed by cycle
    bit            ev [8];
    logic [DW-1:0] ed [8];
    bit            et [8];
    bit            chk_on = 0;
    string         cur_req = "R1";

    int n_chk = 0;
    int n_fail = 0;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        int s;
        if (chk_on) begin
            s = cyc % 8;
            check({cur_req, " R6 rd_valid"}, 32'(rd_valid), 32'(ev[s]));
            if (ev[s]) check({cur_req, " rd_data"}, 32'(rd_data), 32'(ed[s]));
            check("R8 turn_err", 32'(turn_err), 32'(et[s]));
            ev[s] = 0;
            et[s] = 0;
        end
    end

    function automatic logic [DW-1:0] exp_word(int b, int k);
        logic [DW-1:0] w;
        w = mem_m[b][k];
        if (p_v && p_b == b)
            for (int j = 0; j < 2; j++)
                if (!p_be[k][j]) w[j*8 +: 8] = p_d[k][j*8 +: 8];
        return w;
    endfunction

    task automatic write_burst(int b, int seed, int pat, bit full, bit noise);
        logic [DW-1:0] d [4];
        logic [1:0]    be [4];
        int            k;
        for (int i = 0; i < 4; i++) begin
            d[i]  = DW'(seed * 37 + i * 4099 + b * 211 + 1);
            be[i] = full ? 2'b00 : 2'((pat + i) % 4);
        end
        @(negedge clk);
        k = cyc;
        et[(k + 1) % 8] = last_rd && ((k - rd_end) < TN);
        last_rd = 0;
        if (p_v)
            for (int i = 0; i < 4; i++)
                for (int j = 0; j < 2; j++)
                    if (!p_be[i][j]) mem_m[p_b][i][j*8 +: 8] = p_d[i][j*8 +: 8];
        p_v = 1;
        p_b = b;
        for (int i = 0; i < 4; i++) begin
            p_d[i]  = d[i];
            p_be[i] = be[i];
        end
        cmd_valid = 1'b1;
        cmd_write = 1'b1;
        cmd_addr  = {3'(b), 2'b00};
        wr_data   = d[0];
        wr_be_n   = be[0];
        for (int i = 1; i < 4; i++) begin
            @(negedge clk);
            cmd_valid = noise;
            cmd_write = i[0];
            cmd_addr  = {3'(b + 1), 2'b00};
            wr_data   = d[i];
            wr_be_n   = be[i];
        end
    endtask

    task automatic read_burst(int b, int low, bit noise);
        int k;
        @(negedge clk);
        k = cyc;
        for (int i = 0; i < 4; i++) begin
            ev[(k + 1 + i) % 8] = 1;
            ed[(k + 1 + i) % 8] = exp_word(b, i);
        end
        last_rd = 1;
        rd_end = k + 4;
        cmd_valid = 1'b1;
        cmd_write = 1'b0;
        cmd_addr  = {3'(b), 2'(low)};
        for (int i = 1; i < 4; i++) begin
            @(negedge clk);
            cmd_valid = noise;
            cmd_write = i[0];
            cmd_addr  = {3'(b + 2), 2'b00};
            wr_data   = DW'(16'hdead + i);
            wr_be_n   = 2'b00;
        end
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            cmd_valid = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        chk_on = 0;
        cmd_valid = 1'b0;
        rst_n = 1'b0;
        for (int i = 0; i < 8; i++) begin
            ev[i] = 0;
            et[i] = 0;
        end
        p_v = 0;
        last_rd = 0;
        @(negedge clk);
        check("R1 reset rd_valid", 32'(rd_valid), 32'd0);
        check("R1 reset turn_err", 32'(turn_err), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        chk_on = 1;
    endtask

    initial begin
        #(200000 * 10);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            ev[i] = 0;
            et[i] = 0;
        end
        repeat (3) @(negedge clk);
        check("R1 initial rd_valid", 32'(rd_valid), 32'd0);
        check("R1 initial turn_err", 32'(turn_err), 32'd0);
        rst_n = 1'b1;
        @(posedge clk);
        chk_on = 1;

        // R2: full bursts to every location, back to back
        cur_req = "R2";
        for (int b = 0; b < NB; b++) write_burst(b, b, 0, 1, 0);
        // R3: committed bursts read from the array
        cur_req = "R3";
        for (int b = 0; b < NB - 1; b++) read_burst(b, 0, 0);
        // R4: the still-pending burst
        cur_req = "R4";
        read_burst(NB - 1, 0, 0);

        // R5 sweep over byte-enable patterns, with R4 immediate reads and R7 noise
        for (int b = 0; b < NB; b++) begin
            for (int pat = 0; pat < 4; pat++) begin
                cur_req = "R4 R5 R7";
                write_burst(b, 100 + b * 4 + pat, pat, 0, pat == 1);
                read_burst(b, 0, pat == 2);
                cur_req = "R3 R5";
                read_burst((b + 5) % NB, 0, 0);
            end
        end

        // R9: low address bits ignored
        cur_req = "R9";
        read_burst(3, 3, 0);
        read_burst(6, 1, 0);
        write_burst(6, 300, 0, 1, 0);
        idle(1);
        read_burst(6, 2, 0);

        // R8: idle cycles between read and write swept
        cur_req = "R8";
        for (int n = 0; n < 4; n++) begin
            read_burst(n, 0, 0);
            idle(n);
            write_burst(n + 4, 500 + n, 0, 1, 0);
            read_burst(n + 4, 0, 0);
        end
        write_burst(1, 600, 1, 0, 0);
        write_burst(2, 601, 2, 0, 0);

        // R1: reset discards the pending burst and the turnaround history
        cur_req = "R1";
        write_burst(5, 900, 0, 1, 0);
        read_burst(5, 0, 0);
        do_reset();
        write_burst(2, 901, 0, 1, 0);
        read_burst(5, 0, 0);
        read_burst(2, 0, 0);
        idle(4);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule